// File: doc/BRIEF.md
# Stream-to-Memory Input DMA Engine

This engine takes a byte stream from a client and writes it into memory buffers. A chain of data descriptors names those buffers. The stream uses a ready/valid handshake with a last flag that marks the end of a packet. Each descriptor is four little-endian 32-bit words at consecutive word addresses:

- offset 0: next-descriptor pointer
- offset 4: buffer start
- offset 8: flags
- offset 12: buffer end, which is exclusive

A descriptor closes when its buffer becomes full or when a packet ends. On close, the engine does the following:

- It rewrites the end word to the real fill point.
- It marks a packet end in the flags.
- It writes both words back.
- It raises interrupt bits.
- It then follows the next pointer, or stops at end of list.

When the engine stops, it sets the disable bit in the flags word of a context record and writes that word back.

Software starts a chain by pulsing `start_i` with a descriptor pointer and a context pointer. The engine shares a single word-wide memory port between descriptor traffic and data writes. Each accepted byte becomes one single-lane write.

Top module: `s2m_dma_engine`

## Requirements
- R1: After reset, `in_ready_o`, `mem_req_o`, `eol_o`, `irq_o` and `raw_intr_o` are all zero.
- R2: A `start_i` pulse, in the idle or end-of-list state, fetches four words by reads at descriptor pointer +0, +4, +8 and +12, in that order. The words are next, buffer start, flags and end.
- R3: Each accepted byte is written at the current buffer pointer in a single write. The write uses the word address, a one-hot byte enable at lane `ptr[1:0]`, and the byte in that lane. The pointer then advances by one.
- R4: When the pointer reaches the end word, the descriptor closes and no further byte goes to that buffer.
- R5: A byte accepted with `in_last_i` closes the descriptor early. The written-back end word is the address after that byte, and flag bit 12 is set.
- R6: On close, the flags word is written to descriptor +8 and then the end word to descriptor +12, both with all byte enables. This write-back happens before any other descriptor access.
- R7: On close, flag bit 4 set raises raw interrupt bits 0 and 1, and a close caused by `in_last_i` raises bit 3. `irq_o` is the OR of `raw_intr_o & intr_mask_i`. A bit set in `intr_ack_i` clears that raw bit on the next edge.
- R8: If flag bit 0 (eol) is clear, the engine fetches the descriptor at the next pointer and fills from that descriptor's buffer start.
- R9: If flag bit 0 is set, the engine reads the context word at context pointer +4 and writes it back with bit 15 set. It then raises `eol_o`. While `eol_o` is high, `in_ready_o` stays low and no byte is accepted.
- R10: `in_ready_o` is low during descriptor fetch, write-back and context access, and in any cycle where `mem_ready_i` is low.
- R11: A descriptor whose buffer start equals its end closes at once, accepts no byte, and keeps its end word and flags unchanged. It still raises its interrupt bits.
- R12: A `start_i` pulse in the end-of-list state drops `eol_o` on the next edge and runs a new chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a descriptor chain |
| desc_ptr_i | input | ADDR_W | First descriptor address |
| ctx_ptr_i | input | ADDR_W | Context record address |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Byte ends a packet |
| in_ready_o | output | 1 | Engine accepts the byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory takes the request this cycle |
| mem_rdata_i | input | 32 | Read data, valid the cycle after an accepted read |
| intr_mask_i | input | 4 | Interrupt mask |
| intr_ack_i | input | 4 | Clear raw interrupt bits |
| raw_intr_o | output | 4 | Raw interrupt bits |
| irq_o | output | 1 | Masked interrupt |
| eol_o | output | 1 | Chain stopped at end of list |

## Verification
A byte is accepted at the edge where `in_valid_i`, `in_ready_o` and `mem_ready_i` are all high, and its memory write is issued in that same cycle. Raw interrupt bits change at the edge of the closing handshake. An acknowledge clears them one edge after it is driven. `eol_o` rises one edge after the context write is accepted.

The bench drives every input shortly after a falling edge. It samples the handshake 1 ns later and reads results only at falling edges. Memory contents are checked only after `eol_o` has been seen, so the variable latency of fetch and write-back under the bench's stalling memory never leads to an early sample.

// File: rtl/s2m_dma_pkg.sv
package s2m_dma_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_B = WORD_W / 8;
  localparam int RAW_W  = 4;

  // descriptor flag bits
  localparam int F_EOL    = 0;
  localparam int F_INTR   = 4;
  localparam int F_IN_EOP = 12;
  // context flag word
  localparam int C_DIS       = 15;
  localparam int CTX_FLG_OFS = 4;

  // raw interrupt bits
  localparam int I_DONE0 = 0;
  localparam int I_DONE1 = 1;
  localparam int I_EOP   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_WB,
    ST_CTX_RD,
    ST_CTX_WR,
    ST_END
  } st_e;
endpackage

// File: rtl/s2m_lane_fmt.sv
module s2m_lane_fmt #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [7:0]         byte_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [LANES*8-1:0] wdata_o,
  output logic [LANES-1:0]   be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata_o[g*8 +: 8] = byte_i;
    assign be_o[g]           = (off_i == OFF_W'(g));
  end
endmodule

// File: rtl/s2m_intr_bank.sv
module s2m_intr_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q;

  // a set in the same cycle as an ack wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else if ((set_i | ack_i) != '0) raw_q <= (raw_q & ~ack_i) | set_i;
  end

  assign raw_o = raw_q;
  assign irq_o = |(raw_q & mask_i);

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0 && set_i == '0) |=> ((raw_q & $past(ack_i)) == '0));

  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((raw_q & ~$past(raw_q)) == '0));
endmodule

// File: rtl/s2m_dma_engine.sv
module s2m_dma_engine
  import s2m_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   desc_ptr_i,
  input  logic [ADDR_W-1:0]   ctx_ptr_i,
  input  logic                in_valid_i,
  input  logic [7:0]          in_data_i,
  input  logic                in_last_i,
  output logic                in_ready_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_B-1:0]   mem_be_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_ready_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  input  logic [RAW_W-1:0]    intr_mask_i,
  input  logic [RAW_W-1:0]    intr_ack_i,
  output logic [RAW_W-1:0]    raw_intr_o,
  output logic                irq_o,
  output logic                eol_o
);
  localparam int OFF_W = $clog2(WORD_B);

  st_e               st_q;
  logic [ADDR_W-1:0] desc_q, ctx_q, next_q, end_q, ptr_q;
  logic [WORD_W-1:0] flags_q, ctxw_q;
  logic [1:0]        widx_q;
  logic              rd_pend_q;

  logic [WORD_W-1:0] lane_wdata;
  logic [WORD_B-1:0] lane_be;
  logic [RAW_W-1:0]  raw_set;

  logic              room, take, close_empty, close_take, close_now, close_eop, acc;
  logic [ADDR_W-1:0] ptr_inc;

  s2m_lane_fmt #(.LANES(WORD_B)) i_lane (
    .byte_i  (in_data_i),
    .off_i   (ptr_q[OFF_W-1:0]),
    .wdata_o (lane_wdata),
    .be_o    (lane_be)
  );

  assign room        = (ptr_q != end_q);
  assign ptr_inc     = ptr_q + ADDR_W'(1);
  assign take        = (st_q == ST_DATA) && room && in_valid_i && mem_ready_i;
  assign close_empty = (st_q == ST_DATA) && !room;
  assign close_take  = take && (in_last_i || ptr_inc == end_q);
  assign close_now   = close_empty || close_take;
  assign close_eop   = close_take && in_last_i;

  always_comb begin
    raw_set = '0;
    if (close_now && flags_q[F_INTR]) begin
      raw_set[I_DONE0] = 1'b1;
      raw_set[I_DONE1] = 1'b1;
    end
    if (close_eop) raw_set[I_EOP] = 1'b1;
  end

  s2m_intr_bank #(.W(RAW_W)) i_intr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (raw_set),
    .ack_i  (intr_ack_i),
    .mask_i (intr_mask_i),
    .raw_o  (raw_intr_o),
    .irq_o  (irq_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    case (st_q)
      ST_FETCH: begin
        mem_req_o  = !rd_pend_q;
        mem_addr_o = desc_q + ADDR_W'({widx_q, 2'b00});
      end
      ST_DATA: begin
        mem_req_o   = in_valid_i && room;
        mem_we_o    = 1'b1;
        mem_addr_o  = {ptr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
        mem_be_o    = lane_be;
        mem_wdata_o = lane_wdata;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = '1;
        mem_addr_o  = desc_q + ADDR_W'(widx_q[0] ? 12 : 8);
        mem_wdata_o = widx_q[0] ? WORD_W'(end_q) : flags_q;
      end
      ST_CTX_RD: begin
        mem_req_o  = !rd_pend_q;
        mem_addr_o = ctx_q + ADDR_W'(CTX_FLG_OFS);
      end
      ST_CTX_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = '1;
        mem_addr_o  = ctx_q + ADDR_W'(CTX_FLG_OFS);
        mem_wdata_o = ctxw_q;
      end
      default: ;
    endcase
  end

  assign acc        = mem_req_o && mem_ready_i;
  assign in_ready_o = (st_q == ST_DATA) && room && mem_ready_i;
  assign eol_o      = (st_q == ST_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      desc_q    <= '0;
      ctx_q     <= '0;
      next_q    <= '0;
      end_q     <= '0;
      ptr_q     <= '0;
      flags_q   <= '0;
      ctxw_q    <= '0;
      widx_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_END: begin
          if (start_i) begin
            desc_q    <= desc_ptr_i;
            ctx_q     <= ctx_ptr_i;
            widx_q    <= '0;
            rd_pend_q <= 1'b0;
            st_q      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rd_pend_q) begin
            rd_pend_q <= 1'b0;
            case (widx_q)
              2'd0:    next_q  <= mem_rdata_i[ADDR_W-1:0];
              2'd1:    ptr_q   <= mem_rdata_i[ADDR_W-1:0];
              2'd2:    flags_q <= mem_rdata_i;
              default: end_q   <= mem_rdata_i[ADDR_W-1:0];
            endcase
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd3) st_q <= ST_DATA;
          end else if (acc) begin
            rd_pend_q <= 1'b1;
          end
        end
        ST_DATA: begin
          if (take) ptr_q <= ptr_inc;
          if (close_now) begin
            end_q  <= close_take ? ptr_inc : ptr_q;
            widx_q <= '0;
            st_q   <= ST_WB;
          end
          if (close_eop) flags_q[F_IN_EOP] <= 1'b1;
        end
        ST_WB: begin
          if (acc) begin
            if (widx_q == 2'd1) begin
              widx_q <= '0;
              if (flags_q[F_EOL]) begin
                rd_pend_q <= 1'b0;
                st_q      <= ST_CTX_RD;
              end else begin
                desc_q <= next_q;
                st_q   <= ST_FETCH;
              end
            end else begin
              widx_q <= 2'd1;
            end
          end
        end
        ST_CTX_RD: begin
          if (rd_pend_q) begin
            rd_pend_q <= 1'b0;
            ctxw_q    <= mem_rdata_i | (WORD_W'(1) << C_DIS);
            st_q      <= ST_CTX_WR;
          end else if (acc) begin
            rd_pend_q <= 1'b1;
          end
        end
        ST_CTX_WR: if (acc) st_q <= ST_END;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |->
      (mem_req_o && mem_we_o && $onehot(mem_be_o) && mem_addr_o[OFF_W-1:0] == '0));

  a_r5_last_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o);

  a_r8_next_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB && widx_q == 2'd1 && mem_ready_i && !flags_q[F_EOL]) |=>
      (mem_req_o && !mem_we_o && mem_addr_o == $past(next_q)));

  a_r9_eol_after_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ready_i && mem_be_o == '1));

  a_r9_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> !in_ready_o);
endmodule

// File: tb/test_s2m_dma_engine.sv
`timescale 1ns/1ps
module test_s2m_dma_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] desc_ptr_i = '0;
  logic [31:0] ctx_ptr_i = '0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ready_i = 1'b1;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  intr_mask_i = 4'b1000;
  logic [3:0]  intr_ack_i = '0;
  logic [3:0]  raw_intr_o;
  logic        irq_o, eol_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rd_n = 0;
  logic [31:0] rd_addr [0:7];
  logic [31:0] mem [0:255];

  localparam logic [31:0] CTX = 32'h80;

  always #2.5 clk_i = ~clk_i;

  s2m_dma_engine i_s2m_dma_engine (.*);

  // memory model: one-cycle read latency
  always @(posedge clk_i) begin
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[9:2]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o[9:2]];
        if (rd_n < 8) rd_addr[rd_n] <= mem_addr_o;
        rd_n <= rd_n + 1;
      end
    end
  end

  initial begin
    int k = 0;
    forever begin
      @(negedge clk_i);
      k++;
      mem_ready_i = (k % 5) != 2;
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
        finish_up();
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    return mem[a[9:2]][a[1:0]*8 +: 8];
  endfunction

  task automatic put_desc(logic [31:0] a, logic [31:0] nx, logic [31:0] bf,
                          logic [31:0] fl, logic [31:0] en);
    mem[a[9:2]]     = nx;
    mem[a[9:2] + 1] = bf;
    mem[a[9:2] + 2] = fl;
    mem[a[9:2] + 3] = en;
  endtask

  task automatic start_chain(logic [31:0] d);
    @(negedge clk_i);
    start_i = 1'b1;
    desc_ptr_i = d;
    ctx_ptr_i = CTX;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R12 eol dropped after start", {31'd0, eol_o}, 32'd0);
    chk("R10 no ready during fetch", {31'd0, in_ready_o}, 32'd0);
  endtask

  task automatic send(logic [7:0] d, logic last);
    logic ok = 1'b0;
    while (!ok) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_data_i = d;
      in_last_i = last;
      #1;
      ok = in_ready_o;
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i = 1'b0;
  endtask

  task automatic wait_eol();
    int n = 0;
    while (!eol_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk("R9 eol reached", {31'd0, eol_o}, 32'd1);
  endtask

  task automatic ack_all();
    @(negedge clk_i);
    intr_ack_i = 4'hF;
    @(negedge clk_i);
    intr_ack_i = 4'h0;
    chk("R7 ack clears raw", {28'd0, raw_intr_o}, 32'd0);
  endtask

  initial begin
    int run = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 ready", {31'd0, in_ready_o}, 32'd0);
    chk("R1 req", {31'd0, mem_req_o}, 32'd0);
    chk("R1 eol", {31'd0, eol_o}, 32'd0);
    chk("R1 raw", {28'd0, raw_intr_o}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep: offset, length, byte count, end-of-packet
    for (int off = 0; off < 4; off++)
      for (int len = 1; len <= 4; len++)
        for (int k = 1; k <= len; k++)
          for (int lf = 0; lf < 2; lf++) begin
            logic [31:0] bf, fl;
            logic [3:0] exp_raw;
            int refused;
            if (k < len && lf == 0) continue;
            bf = 32'h200 + off;
            fl = 32'h0010_0001 | ((k % 2 == 1) ? 32'h10 : 32'h0);
            for (int w = 0; w < 4; w++) mem[8'h80 + w] = 32'hEEEE_EEEE;
            mem[CTX[9:2] + 1] = 32'h0000_0A05;
            put_desc(32'h100, 32'h0, bf, fl, bf + len);
            start_chain(32'h100);
            for (int i = 0; i < k; i++)
              send(8'(run * 7 + i + 1), (lf == 1) && (i == k - 1));
            wait_eol();
            if (run == 0) begin
              chk("R2 fetch addr 0", rd_addr[0], 32'h100);
              chk("R2 fetch addr 1", rd_addr[1], 32'h104);
              chk("R2 fetch addr 2", rd_addr[2], 32'h108);
              chk("R2 fetch addr 3", rd_addr[3], 32'h10C);
            end
            chk("R5 end word", mem[8'h43], bf + k);
            chk("R6 flags word", mem[8'h42], fl | (lf == 1 ? 32'h1000 : 32'h0));
            for (int i = 0; i < k; i++)
              chk("R3 data byte", {24'd0, rd_byte(bf + i)}, {24'd0, 8'(run * 7 + i + 1)});
            chk("R4 no write past end", {24'd0, rd_byte(bf + k)}, 32'hEE);
            chk("R9 context disable", mem[CTX[9:2] + 1], 32'h0000_8A05);
            exp_raw = ((k % 2 == 1) ? 4'b0011 : 4'b0000) | (lf == 1 ? 4'b1000 : 4'b0000);
            chk("R7 raw bits", {28'd0, raw_intr_o}, {28'd0, exp_raw});
            chk("R7 irq masked", {31'd0, irq_o}, {31'd0, exp_raw[3]});
            refused = 0;
            for (int j = 0; j < 5; j++) begin
              @(negedge clk_i);
              in_valid_i = 1'b1;
              #1;
              if (in_ready_o) refused++;
            end
            @(negedge clk_i);
            in_valid_i = 1'b0;
            chk("R9 refused at end of list", refused, 0);
            ack_all();
            run++;
          end

    // empty descriptor chained to a filled one
    for (int w = 0; w < 4; w++) mem[8'hC0 + w] = 32'hEEEE_EEEE;
    mem[CTX[9:2] + 1] = 32'h0;
    put_desc(32'h140, 32'h160, 32'h300, 32'h10, 32'h300);
    put_desc(32'h160, 32'h0, 32'h302, 32'h1, 32'h306);
    start_chain(32'h140);
    for (int i = 0; i < 4; i++) send(8'(8'hA0 + i), 1'b0);
    wait_eol();
    chk("R11 empty end kept", mem[8'h53], 32'h300);
    chk("R11 empty flags kept", mem[8'h52], 32'h10);
    chk("R11 empty raises intr", {28'd0, raw_intr_o}, 32'h3);
    chk("R8 next end word", mem[8'h5B], 32'h306);
    for (int i = 0; i < 4; i++)
      chk("R8 next buffer data", {24'd0, rd_byte(32'h302 + i)}, {24'd0, 8'(8'hA0 + i)});
    chk("R8 before next buffer untouched", {24'd0, rd_byte(32'h301)}, 32'hEE);
    ack_all();

    // packet end closes first descriptor early, second fills
    for (int w = 0; w < 8; w++) mem[8'hD0 + w] = 32'hEEEE_EEEE;
    put_desc(32'h180, 32'h1A0, 32'h341, 32'h10, 32'h346);
    put_desc(32'h1A0, 32'h0, 32'h360, 32'h1, 32'h362);
    start_chain(32'h180);
    send(8'h51, 1'b0);
    send(8'h52, 1'b1);
    send(8'h53, 1'b0);
    send(8'h54, 1'b0);
    wait_eol();
    chk("R5 early end word", mem[8'h63], 32'h343);
    chk("R5 early flags eop", mem[8'h62], 32'h1010);
    chk("R5 early bytes unused", {24'd0, rd_byte(32'h343)}, 32'hEE);
    chk("R8 second data 0", {24'd0, rd_byte(32'h360)}, 32'h53);
    chk("R8 second data 1", {24'd0, rd_byte(32'h361)}, 32'h54);
    chk("R8 second end", mem[8'h6B], 32'h362);
    chk("R7 eop and done raw", {28'd0, raw_intr_o}, 32'hB);
    chk("R7 irq on eop mask", {31'd0, irq_o}, 32'd1);
    ack_all();
    chk("R7 irq after ack", {31'd0, irq_o}, 32'd0);

    finish_up();
  end
endmodule